// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits between an HDLC deframer and a receive FIFO and decides, one frame at a time, which received bytes reach the FIFO. The deframer has already recognised flags, removed stuffed bits and checked the CRC. It presents a frame as a start strobe, a run of byte strobes and an end strobe. A 3-bit mode input selects how frames are screened. In the service-point mode, the first byte of a frame is compared with two programmable values and two fixed group values. In the terminal-endpoint mode, the second byte is compared with two programmable values and one fixed broadcast value. A frame that matches has the bytes after its address byte written to the FIFO. A frame that does not match is dropped whole.

A third mode bypasses framing altogether. In it the block takes raw serial bits and assembles them into bytes, with the earliest bit in the least significant position. Each completed byte is written. The mode is held for the length of a frame, so software may rewrite it at any time without breaking the frame in progress.

Top module: `hdlc_addr_filter`

## Requirements
- R1: While reset is applied, and in the cycle after it is released, `wr_o` is low.
- R2: With mode 3'b110 (service-point), the first byte after `sof_i` is compared with `sap_a_i`, `sap_b_i`, 8'hFE and 8'hFC. On any hit, every later byte of that frame is written. `wr_o` is high in the cycle after the byte strobe, and `wr_data_o` equals that byte. The address byte itself is not written.
- R3: With mode 3'b101 (terminal-endpoint), only the second byte after `sof_i` is compared, against `tei_a_i`, `tei_b_i` and 8'hFF. On a hit, the bytes from the third onward are written. The first two bytes are never written, and the value of the first byte has no bearing on the decision.
- R4: When the address byte hits none of the compared values, no byte of that frame is written.
- R5: A frame whose `eof_i` arrives before its address byte writes nothing. The following frame is screened afresh.
- R6: The mode is captured at `sof_i`. A change of `mode_i` during a frame takes effect from the next `sof_i` on.
- R7: With mode 3'b100 (raw), each `bit_vld_i` strobe shifts `bit_i` in. The first bit of a group lands in bit 0 of the byte, and the eighth lands in bit 7. On every eighth bit, `wr_o` pulses in the following cycle with the assembled byte, and byte strobes are ignored.
- R8: Any mode value other than 3'b100, 3'b101 and 3'b110 writes nothing.
- R9: In the framed modes, bit strobes are ignored. So are byte strobes that arrive between `eof_i` and the next `sof_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Screening mode: 110 service-point, 101 terminal-endpoint, 100 raw |
| sap_a_i | input | 8 | First programmable service-point value |
| sap_b_i | input | 8 | Second programmable service-point value |
| tei_a_i | input | 8 | First programmable endpoint value |
| tei_b_i | input | 8 | Second programmable endpoint value |
| sof_i | input | 1 | Start-of-frame strobe |
| eof_i | input | 1 | End-of-frame strobe |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| bit_vld_i | input | 1 | Raw bit strobe |
| bit_i | input | 1 | Raw bit |
| wr_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | FIFO write data |

## Verification
The assertions rely on the deframer never raising `sof_i`, `eof_i` and `byte_vld_i` in the same cycle. They also rely on byte and bit strobes never coinciding. Only under those conditions can each write be traced back to exactly one source strobe in the cycle before it. The stimulus drives every strobe as a separate single-cycle pulse. In the raw phase it raises only bit strobes, apart from deliberate stray byte strobes, which it never places in a cycle that also carries a bit.

// File: rtl/hafl_pkg.sv
package hafl_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_RAW  = 3'b100;
  localparam logic [MODE_W-1:0] MODE_TEI  = 3'b101;
  localparam logic [MODE_W-1:0] MODE_SAPI = 3'b110;
  localparam logic [MODE_W-1:0] MODE_NONE = 3'b000;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_HUNT = 2'd1,
    FS_PASS = 2'd2,
    FS_DROP = 2'd3
  } frm_state_t;
endpackage

// File: rtl/hafl_addr_match.sv
module hafl_addr_match #(
  parameter int W = 8,
  parameter int N_FIXED = 2,
  parameter logic [N_FIXED*W-1:0] FIXED = {8'hFE, 8'hFC}
) (
  input  logic [W-1:0] cand_i,
  input  logic [W-1:0] prog_a_i,
  input  logic [W-1:0] prog_b_i,
  output logic         hit_o
);
  localparam int N_ALL = N_FIXED + 2;

  logic [N_ALL-1:0] hits;

  assign hits[0] = (cand_i == prog_a_i);
  assign hits[1] = (cand_i == prog_b_i);

  for (genvar g = 0; g < N_FIXED; g++) begin : g_fixed
    assign hits[g+2] = (cand_i == FIXED[g*W +: W]);
  end

  assign hit_o = |hits;
endmodule

// File: rtl/hafl_bit_packer.sv
module hafl_bit_packer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  output logic         done_o,
  output logic [W-1:0] byte_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             shift_en;

  assign shift_en = en_i && bit_vld_i;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sr_d  = {bit_i, sr_q[W-1:1]};
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign done_o = shift_en && (cnt_q == LAST);
  assign byte_o = {bit_i, sr_q[W-1:1]};
endmodule

// File: rtl/hafl_frame_ctl.sv
module hafl_frame_ctl
  import hafl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [W-1:0]      sap_a_i,
  input  logic [W-1:0]      sap_b_i,
  input  logic [W-1:0]      tei_a_i,
  input  logic [W-1:0]      tei_b_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              byte_vld_i,
  input  logic [W-1:0]      byte_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              pass_o
);
  frm_state_t        st_q, st_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              second_q, second_d;
  logic              sap_hit, tei_hit;

  hafl_addr_match #(.W(W), .N_FIXED(2), .FIXED({8'hFE, 8'hFC})) i_sap_match (
    .cand_i(byte_i), .prog_a_i(sap_a_i), .prog_b_i(sap_b_i), .hit_o(sap_hit)
  );

  hafl_addr_match #(.W(W), .N_FIXED(1), .FIXED(8'hFF)) i_tei_match (
    .cand_i(byte_i), .prog_a_i(tei_a_i), .prog_b_i(tei_b_i), .hit_o(tei_hit)
  );

  always_comb begin
    st_d     = st_q;
    mode_d   = mode_q;
    second_d = second_q;
    if (sof_i || st_q == FS_IDLE) begin
      mode_d = mode_i;
    end
    if (sof_i) begin
      st_d     = FS_HUNT;
      second_d = 1'b0;
    end else if (eof_i) begin
      st_d = FS_IDLE;
    end else if (byte_vld_i && st_q == FS_HUNT) begin
      if (mode_q == MODE_SAPI) begin
        st_d = sap_hit ? FS_PASS : FS_DROP;
      end else if (mode_q == MODE_TEI) begin
        if (!second_q) begin
          second_d = 1'b1;
        end else begin
          st_d = tei_hit ? FS_PASS : FS_DROP;
        end
      end else begin
        st_d = FS_DROP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FS_IDLE;
      mode_q   <= MODE_NONE;
      second_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      mode_q   <= mode_d;
      second_q <= second_d;
    end
  end

  assign mode_o = mode_q;
  assign pass_o = (st_q == FS_PASS) && byte_vld_i && !sof_i && !eof_i;
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hafl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] sap_a_i,
  input  logic [DATA_W-1:0] sap_b_i,
  input  logic [DATA_W-1:0] tei_a_i,
  input  logic [DATA_W-1:0] tei_b_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [MODE_W-1:0] act_mode;
  logic              frm_pass;
  logic              raw_en, raw_done;
  logic [DATA_W-1:0] raw_byte;
  logic              wr_d;
  logic [DATA_W-1:0] data_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  hafl_frame_ctl #(.W(DATA_W)) i_frame (
    .clk(clk), .rst_n(rst_int_n), .mode_i(mode_i),
    .sap_a_i(sap_a_i), .sap_b_i(sap_b_i), .tei_a_i(tei_a_i), .tei_b_i(tei_b_i),
    .sof_i(sof_i), .eof_i(eof_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .mode_o(act_mode), .pass_o(frm_pass)
  );

  assign raw_en = (act_mode == MODE_RAW);

  hafl_bit_packer #(.W(DATA_W)) i_packer (
    .clk(clk), .rst_n(rst_int_n), .en_i(raw_en),
    .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .done_o(raw_done), .byte_o(raw_byte)
  );

  always_comb begin
    wr_d   = 1'b0;
    data_d = wr_data_o;
    if (raw_en) begin
      if (raw_done) begin
        wr_d   = 1'b1;
        data_d = raw_byte;
      end
    end else if (frm_pass) begin
      wr_d   = 1'b1;
      data_d = byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wr_o      <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_o <= wr_d;
      if (wr_d) wr_data_o <= data_d;
    end
  end
endmodule

// File: rtl/hafl_checker.sv
module hafl_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sof_i,
  input logic              eof_i,
  input logic              byte_vld_i,
  input logic [DATA_W-1:0] byte_i,
  input logic              bit_vld_i,
  input logic              bit_i,
  input logic              wr_o,
  input logic [DATA_W-1:0] wr_data_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_idle_in_reset_r1: assert (wr_o == 1'b0)
        else $error("wr_o high during reset");
    end
  end

  p_write_has_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> $past(byte_vld_i || bit_vld_i));

  p_byte_data_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && $past(byte_vld_i)) |-> (wr_data_o == $past(byte_i)));

  p_sof_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sof_i) |-> !wr_o);

  p_eof_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eof_i) |-> !wr_o);

  p_raw_msb_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && $past(bit_vld_i)) |-> (wr_data_o[DATA_W-1] == $past(bit_i)));
endmodule

bind hdlc_addr_filter hafl_checker #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .eof_i(eof_i),
  .byte_vld_i(byte_vld_i), .byte_i(byte_i), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
  .wr_o(wr_o), .wr_data_o(wr_data_o)
);

// File: tb/test_hdlc_addr_filter.sv
module test_hdlc_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic [7:0] sap_a_i = 8'h00, sap_b_i = 8'h00, tei_a_i = 8'h00, tei_b_i = 8'h00;
  logic       sof_i = 1'b0, eof_i = 1'b0, byte_vld_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       wr_o;
  logic [7:0] wr_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hdlc_addr_filter i_hdlc_addr_filter (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .sap_a_i(sap_a_i), .sap_b_i(sap_b_i), .tei_a_i(tei_a_i), .tei_b_i(tei_b_i),
    .sof_i(sof_i), .eof_i(eof_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .bit_vld_i(bit_vld_i), .bit_i(bit_i), .wr_o(wr_o), .wr_data_o(wr_data_o)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic [7:0] sa, sb, ta, tb, a0, a1;
    logic [2:0] nwr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'b110, 8'h10, 8'h20, 8'h00, 8'h00, 8'h10, 8'h99, 3'd3, 4'd2},
    '{3'b110, 8'h10, 8'h20, 8'h00, 8'h00, 8'h20, 8'h99, 3'd3, 4'd2},
    '{3'b110, 8'h10, 8'h20, 8'h00, 8'h00, 8'hFE, 8'h10, 3'd3, 4'd2},
    '{3'b110, 8'h10, 8'h20, 8'h00, 8'h00, 8'hFC, 8'h00, 3'd3, 4'd2},
    '{3'b110, 8'h10, 8'h20, 8'h00, 8'h00, 8'hFD, 8'h10, 3'd0, 4'd4},
    '{3'b110, 8'h10, 8'h20, 8'h00, 8'h00, 8'h55, 8'hFE, 3'd0, 4'd4},
    '{3'b101, 8'h00, 8'h00, 8'h33, 8'h44, 8'h77, 8'h33, 3'd2, 4'd3},
    '{3'b101, 8'h00, 8'h00, 8'h33, 8'h44, 8'h00, 8'h44, 3'd2, 4'd3},
    '{3'b101, 8'h00, 8'h00, 8'h33, 8'h44, 8'h12, 8'hFF, 3'd2, 4'd3},
    '{3'b101, 8'h00, 8'h00, 8'h33, 8'h44, 8'h33, 8'h34, 3'd0, 4'd4},
    '{3'b000, 8'hFE, 8'h20, 8'h33, 8'h44, 8'hFE, 8'h33, 3'd0, 4'd8}
  };

  task automatic check_out(input string req, input logic exp_wr, input logic [7:0] exp_data);
    n_chk++;
    if (wr_o !== exp_wr || (exp_wr && wr_data_o !== exp_data)) begin
      n_fail++;
      $display("FAIL %s: wr=%b data=%h expected wr=%b data=%h", req, wr_o, wr_data_o, exp_wr, exp_data);
    end
  endtask

  task automatic pulse_sof(input string req);
    sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0;
    check_out(req, 1'b0, 8'h00);
  endtask

  task automatic pulse_eof(input string req);
    eof_i = 1'b1;
    @(negedge clk);
    eof_i = 1'b0;
    check_out(req, 1'b0, 8'h00);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_wr, input string req);
    byte_vld_i = 1'b1;
    byte_i = b;
    @(negedge clk);
    byte_vld_i = 1'b0;
    check_out(req, exp_wr, b);
  endtask

  task automatic send_bit(input logic v, input logic exp_wr, input logic [7:0] exp_data, input string req);
    bit_vld_i = 1'b1;
    bit_i = v;
    @(negedge clk);
    bit_vld_i = 1'b0;
    check_out(req, exp_wr, exp_data);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_out("R1", 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1", 1'b0, 8'h00);
    repeat (3) @(negedge clk);

    // R2 R3 R4 R8: frame table
    for (int v = 0; v < NV; v++) begin
      logic [7:0] fb [4];
      mode_i  = VEC[v].mode;
      sap_a_i = VEC[v].sa;
      sap_b_i = VEC[v].sb;
      tei_a_i = VEC[v].ta;
      tei_b_i = VEC[v].tb;
      fb[0] = VEC[v].a0;
      fb[1] = VEC[v].a1;
      fb[2] = 8'h5A ^ 8'(v);
      fb[3] = 8'hC3 + 8'(v);
      @(negedge clk);
      pulse_sof($sformatf("R%0d vec%0d sof", VEC[v].req, v));
      for (int k = 0; k < 4; k++) begin
        send_byte(fb[k], (k >= 4 - int'(VEC[v].nwr)), $sformatf("R%0d vec%0d byte%0d", VEC[v].req, v, k));
      end
      pulse_eof($sformatf("R%0d vec%0d eof", VEC[v].req, v));
    end

    // R9: bytes between frames are ignored
    mode_i = 3'b110; sap_a_i = 8'h10;
    send_byte(8'h10, 1'b0, "R9 stray addr");
    send_byte(8'h66, 1'b0, "R9 stray data");

    // R5: frames that end before the address byte
    pulse_sof("R5 sof");
    pulse_eof("R5 empty eof");
    pulse_sof("R5 sof2");
    send_byte(8'h10, 1'b0, "R5 addr after empty");
    send_byte(8'h81, 1'b1, "R5 next frame screened afresh");
    pulse_eof("R5 eof2");
    mode_i = 3'b101; tei_a_i = 8'h33;
    @(negedge clk);
    pulse_sof("R5 tei sof");
    send_byte(8'h33, 1'b0, "R5 tei first only");
    pulse_eof("R5 tei short eof");
    pulse_sof("R5 tei sof2");
    send_byte(8'h00, 1'b0, "R5 tei byte0");
    send_byte(8'h33, 1'b0, "R5 tei byte1");
    send_byte(8'h92, 1'b1, "R5 tei byte2");
    pulse_eof("R5 tei eof2");

    // R6: mode captured at sof
    mode_i = 3'b110; sap_a_i = 8'h10;
    @(negedge clk);
    pulse_sof("R6 sof");
    mode_i = 3'b000;
    send_byte(8'h10, 1'b0, "R6 addr");
    send_byte(8'h4D, 1'b1, "R6 kept mode mid frame");
    pulse_eof("R6 eof");
    pulse_sof("R6 sof new mode");
    send_byte(8'h10, 1'b0, "R6 addr new mode");
    send_byte(8'h4E, 1'b0, "R6 new mode applies");
    pulse_eof("R6 eof2");

    // R9: bit strobes ignored in a passing framed frame
    mode_i = 3'b110;
    @(negedge clk);
    pulse_sof("R9 sof");
    send_byte(8'hFE, 1'b0, "R9 addr");
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0, 8'h00, "R9 bit ignored");
    send_byte(8'h21, 1'b1, "R9 data after bits");
    pulse_eof("R9 eof");

    // R7: raw mode, LSB-first packing
    mode_i = 3'b100;
    repeat (2) @(negedge clk);
    send_byte(8'h77, 1'b0, "R7 byte ignored in raw");
    begin
      logic [7:0] pat [2];
      pat[0] = 8'hA5;
      pat[1] = 8'h3C;
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < 8; i++) begin
          send_bit(pat[p][i], (i == 7), pat[p], $sformatf("R7 raw byte%0d bit%0d", p, i));
          if (i == 3) @(negedge clk);
        end
      end
      for (int i = 0; i < 8; i++) send_bit(i[0], (i == 7), 8'hAA, $sformatf("R7 raw alt bit%0d", i));
    end
    mode_i = 3'b110;
    repeat (2) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule